// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Atomic Set/Clear

This block is a register-mapped general-purpose I/O controller for up to four banks of 32 pins. Software changes an output latch through two write-only registers per bank. One register sets latches and the other clears them. Only the pins whose data bit is 1 are touched, so no read-modify-write is needed to change one pin and two agents cannot race on a shared data register. A readable direction register chooses between input and output for each pin. A level register reports the synchronized state of every pad. Two function-select registers per bank hold a 2-bit alternate-function code for each pin.

The latch drives the pad output at all times, whatever the direction. Software can therefore preload a level while a pin is still an input, then turn the driver on without the pad passing through the old value. The last bank can be built with fewer than 32 pins. Its missing pins read as 0, take no writes and drive nothing.

The bus is a plain synchronous interface. The word address, write enable and write data are sampled at a rising edge. Read data is registered and shows the addressed register one clock after the address is presented.

Top module: `gpio_bank_top`

## Requirements
- R1: After reset, every direction bit, output latch and function field is 0, so `padOe`, `padOut` and `padFunc` are all 0.
- R2: A write to offset 2 of a bank sets the output latch of each pin whose data bit is 1. Pins whose data bit is 0 keep their latch.
- R3: A write to offset 3 of a bank clears the output latch of each pin whose data bit is 1. Pins whose data bit is 0 keep their latch.
- R4: Offset 1 is the direction register and can be read and written. Bit p = 1 makes pin p an output, and `padOe` for that pin follows the bit one clock after the write.
- R5: A read of offset 0 returns the level of every pin in the bank, whether input or output, taken from `padIn` through a two-flop synchronizer. A write to offset 0 has no effect.
- R6: Offset 4 holds the 2-bit function codes of pins 0 to 15 and offset 5 those of pins 16 to 31. The field for pin p sits at bits (p mod 16)*2+1 to (p mod 16)*2. Both registers read back and drive `padFunc[2g+1:2g]` for global pin g.
- R7: `padOut` shows the output latch regardless of direction. A level loaded through offset 2 or 3 while the pin is an input appears unchanged on the pad once the direction bit goes to 1.
- R8: Word address = bank*8 + offset. Bank n serves global pins 32n to 32n+31.
- R9: The last bank implements only LAST_BANK_PINS pins (21 by default). Its higher bits read 0, ignore writes, and drive 0 on `padOut`, `padOe` and `padFunc`.
- R10: Reads of offsets 2, 3, 6 and 7 return 0. Writes to offsets 6 and 7 have no effect.
- R11: `padOut` changes only after a write to offset 2 or 3. `padOe` changes only after a write to offset 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Word address: bank above bit 3, register offset in bits 2:0 |
| busWrEn | input | 1 | Write strobe, sampled at the rising edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data for the previous cycle's address |
| padIn | input | NUM_BANKS*32 | Sampled pad levels |
| padOut | output | NUM_BANKS*32 | Output latch per pin |
| padOe | output | NUM_BANKS*32 | Output enable per pin (1 = drive) |
| padFunc | output | NUM_BANKS*64 | 2-bit alternate-function code per pin |

## Verification
The hardest case to reach is a preloaded level that must survive a change of direction. The latch has to be set or cleared while the pin is still an input, and then the direction bit must be raised. A pad loopback in the bench, plus an external drive pattern that differs from the latch, makes a premature or stale value visible both on `padOut` and in the level register. Directed sequences cover that handover and the partial last bank. Seeded random traffic mixes writes to every offset and bank with changes of the external drive. Each level read is preceded by idle cycles, so the synchronizer has settled before the expected pad state is compared.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Pins served by one bank; equals the bus data width.
  localparam int unsigned BANK_PINS = 32;
  localparam int unsigned OFF_W     = 3;

  typedef enum logic [OFF_W-1:0] {
    OFF_LEVEL = 3'd0,
    OFF_DIR   = 3'd1,
    OFF_SET   = 3'd2,
    OFF_CLR   = 3'd3,
    OFF_FNLO  = 3'd4,
    OFF_FNHI  = 3'd5
  } regOff_e;

  // Strobes from the decoder into the datapath.
  typedef struct packed {
    logic wrDir;
    logic wrSet;
    logic wrClr;
    logic wrFnLo;
    logic wrFnHi;
    logic rdLevel;
    logic rdDir;
    logic rdFnLo;
    logic rdFnHi;
  } strobes_t;

  // Mask with the lowest n bits set.
  function automatic logic [BANK_PINS-1:0] pinMask(int unsigned n);
    logic [BANK_PINS-1:0] m;
    for (int i = 0; i < BANK_PINS; i++) begin
      m[i] = (i < n);
    end
    return m;
  endfunction

  // Widen a per-pin mask to a per-field mask (2 bits per pin).
  function automatic logic [2*BANK_PINS-1:0] fieldMask(logic [BANK_PINS-1:0] m);
    logic [2*BANK_PINS-1:0] f;
    for (int i = 0; i < BANK_PINS; i++) begin
      f[2*i]   = m[i];
      f[2*i+1] = m[i];
    end
    return f;
  endfunction

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned BANK_W    = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output strobes_t          stb,
  output logic [BANK_W-1:0] bankIdx
);

  localparam int unsigned FIELD_W = ADDR_W - OFF_W;
  localparam logic [FIELD_W-1:0] LAST_BANK = FIELD_W'(NUM_BANKS - 1);

  logic [FIELD_W-1:0] bankField;
  regOff_e            regOff;
  logic               bankHit;
  logic               wrHit;

  assign bankField = busAddr[ADDR_W-1:OFF_W];
  assign regOff    = regOff_e'(busAddr[OFF_W-1:0]);
  assign bankHit   = (bankField <= LAST_BANK);
  assign bankIdx   = bankField[BANK_W-1:0];
  assign wrHit     = busWrEn && bankHit;

  always_comb begin
    stb         = '0;
    stb.wrDir   = wrHit && (regOff == OFF_DIR);
    stb.wrSet   = wrHit && (regOff == OFF_SET);
    stb.wrClr   = wrHit && (regOff == OFF_CLR);
    stb.wrFnLo  = wrHit && (regOff == OFF_FNLO);
    stb.wrFnHi  = wrHit && (regOff == OFF_FNHI);
    stb.rdLevel = bankHit && (regOff == OFF_LEVEL);
    stb.rdDir   = bankHit && (regOff == OFF_DIR);
    stb.rdFnLo  = bankHit && (regOff == OFF_FNLO);
    stb.rdFnHi  = bankHit && (regOff == OFF_FNHI);
  end

endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS      = 4,
  parameter int unsigned LAST_BANK_PINS = 21,
  parameter int unsigned BANK_W         = 2,
  localparam int unsigned NPINS         = NUM_BANKS * BANK_PINS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              stb,
  input  logic [BANK_W-1:0]     bankIdx,
  input  logic [BANK_PINS-1:0]  wrData,
  input  logic [NPINS-1:0]      padIn,
  output logic [NPINS-1:0]      padOut,
  output logic [NPINS-1:0]      padOe,
  output logic [2*NPINS-1:0]    padFunc,
  output logic [BANK_PINS-1:0]  rdData
);

  // Two-flop synchronizer for the pad levels.
  logic [NPINS-1:0] syncA;
  logic [NPINS-1:0] syncB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  logic [NUM_BANKS-1:0][BANK_PINS-1:0] bankRd;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned IMPL =
      (b == NUM_BANKS - 1) ? LAST_BANK_PINS : BANK_PINS;
    localparam logic [BANK_PINS-1:0]   PMASK = pinMask(IMPL);
    localparam logic [2*BANK_PINS-1:0] FMASK = fieldMask(PMASK);

    logic                   sel;
    logic [BANK_PINS-1:0]   dirQ;
    logic [BANK_PINS-1:0]   outQ;
    logic [2*BANK_PINS-1:0] fnQ;
    logic [BANK_PINS-1:0]   rdWord;

    assign sel = (bankIdx == BANK_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirQ <= '0;
        outQ <= '0;
        fnQ  <= '0;
      end else begin
        if (sel && stb.wrDir) begin
          dirQ <= wrData & PMASK;
        end
        if (sel && stb.wrSet) begin
          outQ <= outQ | (wrData & PMASK);
        end else if (sel && stb.wrClr) begin
          outQ <= outQ & ~(wrData & PMASK);
        end
        if (sel && stb.wrFnLo) begin
          fnQ[BANK_PINS-1:0] <= wrData & FMASK[BANK_PINS-1:0];
        end
        if (sel && stb.wrFnHi) begin
          fnQ[2*BANK_PINS-1:BANK_PINS] <= wrData & FMASK[2*BANK_PINS-1:BANK_PINS];
        end
      end
    end

    // The latch drives the pad even while the pin is an input.
    assign padOut[b*BANK_PINS +: BANK_PINS]      = outQ;
    assign padOe[b*BANK_PINS +: BANK_PINS]       = dirQ;
    assign padFunc[2*b*BANK_PINS +: 2*BANK_PINS] = fnQ;

    always_comb begin
      rdWord = '0;
      if (sel) begin
        if (stb.rdLevel) rdWord = syncB[b*BANK_PINS +: BANK_PINS] & PMASK;
        if (stb.rdDir)   rdWord = dirQ;
        if (stb.rdFnLo)  rdWord = fnQ[BANK_PINS-1:0];
        if (stb.rdFnHi)  rdWord = fnQ[2*BANK_PINS-1:BANK_PINS];
      end
    end

    assign bankRd[b] = rdWord;
  end

  logic [BANK_PINS-1:0] rdNext;

  always_comb begin
    rdNext = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      rdNext = rdNext | bankRd[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else begin
      rdData <= rdNext;
    end
  end

endmodule

// File: rtl/gpio_bank_top.sv
module gpio_bank_top
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS      = 4,
  parameter int unsigned LAST_BANK_PINS = 21,
  parameter int unsigned ADDR_W         = 5,
  localparam int unsigned NPINS         = NUM_BANKS * BANK_PINS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [BANK_PINS-1:0] busWrData,
  output logic [BANK_PINS-1:0] busRdData,
  input  logic [NPINS-1:0]     padIn,
  output logic [NPINS-1:0]     padOut,
  output logic [NPINS-1:0]     padOe,
  output logic [2*NPINS-1:0]   padFunc
);

  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  strobes_t          stb;
  logic [BANK_W-1:0] bankIdx;

  gpio_bank_ctrl #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W)
  ) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .stb     (stb),
    .bankIdx (bankIdx)
  );

  gpio_bank_datapath #(
    .NUM_BANKS      (NUM_BANKS),
    .LAST_BANK_PINS (LAST_BANK_PINS),
    .BANK_W         (BANK_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .bankIdx (bankIdx),
    .wrData  (busWrData),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .padFunc (padFunc),
    .rdData  (busRdData)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned NUM_BANKS      = 4,
  parameter int unsigned LAST_BANK_PINS = 21,
  parameter int unsigned ADDR_W         = 5,
  localparam int unsigned NPINS         = NUM_BANKS * 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [31:0]       busWrData,
  input logic [31:0]       busRdData,
  input logic [NPINS-1:0]  padOut,
  input logic [NPINS-1:0]  padOe
);

  function automatic logic [NPINS-1:0] implVec();
    logic [NPINS-1:0] v;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int i = 0; i < 32; i++) begin
        v[b*32+i] = (i < ((b == NUM_BANKS - 1) ? LAST_BANK_PINS : 32));
      end
    end
    return v;
  endfunction

  localparam logic [NPINS-1:0] IMPL = implVec();

  logic [2:0]        off;
  logic [ADDR_W-4:0] bankF;
  logic [NPINS-1:0]  wrVec;
  logic [NPINS-1:0]  bankVec;
  logic              bankOk;

  assign off     = busAddr[2:0];
  assign bankF   = busAddr[ADDR_W-1:3];
  assign bankOk  = (int'(bankF) < NUM_BANKS);
  assign wrVec   = (NPINS'(busWrData) << (int'(bankF) * 32)) & IMPL;
  assign bankVec = NPINS'(32'hFFFF_FFFF) << (int'(bankF) * 32);

  assert_set_drives_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && off == 3'd2) |=> ((padOut & $past(wrVec)) == $past(wrVec)));

  assert_clear_drives_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && off == 3'd3) |=> ((padOut & $past(wrVec)) == '0));

  assert_dir_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && off == 3'd1 && bankOk) |=> ((padOe & $past(bankVec)) == $past(wrVec)));

  assert_unimpl_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((padOut | padOe) & ~IMPL) == '0);

  assert_zero_reads_R10: assert property (@(posedge clk) disable iff (!rstN)
    (off == 3'd2 || off == 3'd3 || off == 3'd6 || off == 3'd7) |=> (busRdData == '0));

  assert_out_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    (padOut != $past(padOut)) |-> $past(busWrEn && (off == 3'd2 || off == 3'd3)));

  assert_oe_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    (padOe != $past(padOe)) |-> $past(busWrEn && off == 3'd1));

endmodule

bind gpio_bank_top gpio_bank_chk #(
  .NUM_BANKS      (NUM_BANKS),
  .LAST_BANK_PINS (LAST_BANK_PINS),
  .ADDR_W         (ADDR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .padOut    (padOut),
  .padOe     (padOe)
);

// File: tb/gpio_bank_top_tb.sv
module gpio_bank_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_BANKS  = 4;
  localparam int LAST_PINS  = 21;
  localparam int ADDR_W     = 5;
  localparam int NPINS      = NUM_BANKS * 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic [NPINS-1:0]  padIn;
  logic [NPINS-1:0]  padOut;
  logic [NPINS-1:0]  padOe;
  logic [2*NPINS-1:0] padFunc;
  logic [NPINS-1:0]  extDrive = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] mDir [NUM_BANKS];
  logic [31:0] mOut [NUM_BANKS];
  logic [63:0] mFn  [NUM_BANKS];

  always #(CLK_PERIOD/2) clk = ~clk;

  // Pad loopback: a driven pin sees its own output.
  assign padIn = (padOe & padOut) | (~padOe & extDrive);

  gpio_bank_top #(
    .NUM_BANKS      (NUM_BANKS),
    .LAST_BANK_PINS (LAST_PINS),
    .ADDR_W         (ADDR_W)
  ) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .padFunc   (padFunc)
  );

  function automatic logic [31:0] bankMask(int b);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (b != NUM_BANKS - 1) || (i < LAST_PINS);
    return m;
  endfunction

  function automatic logic [63:0] fnMask(int b);
    logic [63:0] f;
    logic [31:0] m;
    m = bankMask(b);
    for (int i = 0; i < 32; i++) begin
      f[2*i] = m[i];
      f[2*i+1] = m[i];
    end
    return f;
  endfunction

  function automatic logic [31:0] expRead(int b, int off);
    logic [31:0] lvl;
    lvl = ((mDir[b] & mOut[b]) | (~mDir[b] & extDrive[b*32 +: 32])) & bankMask(b);
    case (off)
      0:       return lvl;
      1:       return mDir[b];
      4:       return mFn[b][31:0];
      5:       return mFn[b][63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reqOf(int off);
    case (off)
      0:       return "R5";
      1:       return "R4";
      4, 5:    return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic modelWrite(int b, int off, logic [31:0] d);
    logic [31:0] dm;
    dm = d & bankMask(b);
    case (off)
      1: mDir[b] = dm;
      2: mOut[b] = mOut[b] | dm;
      3: mOut[b] = mOut[b] & ~dm;
      4: mFn[b][31:0]  = d & fnMask(b)[31:0];
      5: mFn[b][63:32] = d & fnMask(b)[63:32];
      default: ;
    endcase
  endtask

  task automatic busWrite(int b, int off, logic [31:0] d);
    @(negedge clk);
    busAddr   = ADDR_W'(b*8 + off);
    busWrEn   = 1'b1;
    busWrData = d;
    @(posedge clk);
    #1;
    busWrEn = 1'b0;
    modelWrite(b, off, d);
  endtask

  task automatic busRead(int b, int off, output logic [31:0] q);
    @(negedge clk);
    busAddr = ADDR_W'(b*8 + off);
    busWrEn = 1'b0;
    @(posedge clk);
    #1;
    q = busRdData;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkPads();
    for (int b = 0; b < NUM_BANKS; b++) begin
      check("R7", $sformatf("padOut bank %0d", b), 64'(padOut[b*32 +: 32]), 64'(mOut[b]));
      check("R4", $sformatf("padOe bank %0d", b), 64'(padOe[b*32 +: 32]), 64'(mDir[b]));
      check("R6", $sformatf("padFunc bank %0d", b), padFunc[b*64 +: 64], mFn[b]);
    end
  endtask

  task automatic readCheck(int b, int off);
    logic [31:0] q;
    if (off == 0) idle(3);
    busRead(b, off, q);
    check(reqOf(off), $sformatf("R8 read bank %0d off %0d", b, off), 64'(q), 64'(expRead(b, off)));
  endtask

  initial begin : main
    logic [31:0] q;
    for (int b = 0; b < NUM_BANKS; b++) begin
      mDir[b] = '0;
      mOut[b] = '0;
      mFn[b]  = '0;
    end
    void'($urandom(32'h5EED_0123));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;

    // R1: reset state at the pads and in the registers
    check("R1", "padOut after reset", 64'(padOut[63:0]) | 64'(padOut[127:64]), 64'h0);
    check("R1", "padOe after reset", 64'(padOe[63:0]) | 64'(padOe[127:64]), 64'h0);
    check("R1", "padFunc after reset", 64'($countones(padFunc)), 64'h0);
    busRead(0, 1, q); check("R1", "dir bank0 after reset", 64'(q), 64'h0);
    busRead(2, 5, q); check("R1", "fnHi bank2 after reset", 64'(q), 64'h0);

    // R7: preload while input, then enable the driver
    extDrive = '0;
    busWrite(0, 2, 32'h0000_0020);
    check("R7", "preloaded padOut[5]", 64'(padOut[5]), 64'h1);
    check("R7", "padOe[5] still input", 64'(padOe[5]), 64'h0);
    busWrite(0, 1, 32'h0000_0020);
    check("R7", "padOut[5] after enable", 64'(padOut[5]), 64'h1);
    check("R4", "padOe[5] after enable", 64'(padOe[5]), 64'h1);
    readCheck(0, 0);
    busWrite(0, 3, 32'h0000_0020);
    check("R3", "padOut[5] cleared", 64'(padOut[5]), 64'h0);
    readCheck(0, 0);

    // R2 R3: untouched bits keep their latch
    busWrite(1, 2, 32'hF0F0_0000);
    busWrite(1, 3, 32'h3000_0000);
    check("R2", "bank1 latch after set then clear", 64'(padOut[63:32]), 64'hC0F0_0000);

    // R8: bank 2 pin 0 is global pin 64
    busWrite(2, 2, 32'h0000_0001);
    check("R8", "global pin 64", 64'(padOut[64]), 64'h1);
    checkPads();

    // R9: partial last bank
    busWrite(3, 1, 32'hFFFF_FFFF);
    busRead(3, 1, q);
    check("R9", "last bank dir readback", 64'(q), 64'h001F_FFFF);
    busWrite(3, 2, 32'hFFFF_FFFF);
    check("R9", "unimplemented padOut", 64'(padOut[127:117]), 64'h0);
    busWrite(3, 5, 32'hFFFF_FFFF);
    busRead(3, 5, q);
    check("R9", "last bank fnHi readback", 64'(q), 64'h0000_03FF);
    extDrive = '1;
    readCheck(3, 0);

    // R10: set/clear and unmapped reads; R5: write to level ignored
    readCheck(1, 2);
    readCheck(1, 3);
    busWrite(2, 6, 32'hFFFF_FFFF);
    busWrite(2, 0, 32'hFFFF_FFFF);
    readCheck(2, 7);
    checkPads();

    // Constrained random mix
    for (int n = 0; n < 600; n++) begin
      int b;
      int off;
      int op;
      b   = int'($urandom % NUM_BANKS);
      off = int'($urandom % 8);
      op  = int'($urandom % 4);
      if (op < 2) begin
        busWrite(b, off, $urandom);
        checkPads();
      end else if (op == 2) begin
        readCheck(b, off);
      end else begin
        extDrive = {$urandom, $urandom, $urandom, $urandom};
        readCheck(b, 0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule